// File: doc/BRIEF.md
# Converter Start and Trigger Sequencing Controller

This block decides when an analog-to-digital conversion begins and reports, for the whole conversion, that the converter is busy. Software can request one conversion with a start strobe. With auto-triggering turned on, a rising edge on one of several trigger lines also starts a conversion. A 3-bit selector chooses the trigger line. Selector value 0 chooses the block's own completion flag, which puts the controller in free-running mode. Selector values 1 to 7 choose the external lines `trig_in[0]` to `trig_in[6]`.

Each start clears the conversion-clock prescaler and latches the requested channel. The sequencer then counts a fixed 13 prescaled ticks. At the end of the count the controller sets the completion flag and writes a result from a stub in place of a real converter. The flag is set on every completion. Whatever interrupt logic sits around the block has no effect on it. A power-down input blocks every kind of start.

Top module: `adc_start_ctrl`

## Requirements
- R1: A one-cycle `start_wr` pulse with `pwr_off` low and `busy` low starts a conversion. While `pwr_off` is high, neither `start_wr` nor a trigger edge starts one.
- R2: `busy` rises at the clock edge that accepts the start. It then stays high for exactly 13×R cycles, where R = 2 for `psc_sel` 0 or 1 and R = 2^`psc_sel` otherwise. At the end of that time `busy` falls, unless R7 applies.
- R3: `cur_chan` takes the value of `chan_sel` at the start edge. A change of `chan_sel` during a conversion does not affect `cur_chan` or the channel field of that conversion's result.
- R4: With `auto_en` high, a rising edge on the selected trigger starts a conversion and clears the prescaler. With `auto_en` low, trigger edges have no effect.
- R5: A trigger edge that arrives while `busy` is high is ignored. A trigger that is still high when a conversion ends does not start another one.
- R6: `cmp_flag` is set at every completion. A `flag_clr` pulse clears it. If a clear and a completion fall in the same cycle, the flag stays set.
- R7: With `auto_en` high and `trig_sel` = 0, a new conversion begins at the same edge that ends the previous one, whatever the state of `cmp_flag`. The first conversion in this mode still needs `start_wr`.
- R8: `start_wr` starts a conversion whether `auto_en` is high or low.
- R9: Moving `trig_sel` onto a trigger line that is already high does not count as an edge.
- R10: At each completion, `result` is loaded with {channel (upper 4 bits), number of earlier completions since reset mod 64 (lower 6 bits)}.
- R11: After reset, `busy`, `cmp_flag`, `cur_chan` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_wr | input | 1 | Software start strobe (one-cycle pulse) |
| pwr_off | input | 1 | Converter powered down; blocks all starts |
| auto_en | input | 1 | Enables trigger-driven starts |
| trig_sel | input | 3 | Trigger select: 0 = own flag, k = trig_in[k-1] |
| trig_in | input | 7 | External trigger lines |
| psc_sel | input | 3 | Prescaler ratio select |
| chan_sel | input | 4 | Requested channel |
| flag_clr | input | 1 | Clear strobe for the completion flag |
| busy | output | 1 | Conversion in progress (start bit readback) |
| cmp_flag | output | 1 | Completion flag |
| cur_chan | output | 4 | Channel latched for the current or last conversion |
| result | output | 10 | Stub result of the last completed conversion |

## Verification
Most internal faults show up at the ports within one conversion. A prescaler that was not cleared, or a tick counter that is off, changes the width of the `busy` pulse by at least one cycle. That is caught when `busy` falls, at most 13×128 cycles after the start. A faulty edge detector or start gate shows up as a `busy` rise one cycle after the stimulus that should or should not cause it. A wrong flag or free-running decision shows up at the completion edge. There, `busy` either stays high or drops, and `result` shows the channel that was actually latched.

// File: rtl/adc_ctrl_pkg.sv
// Package: shared helpers for the conversion start controller.
// Assumes prescaler ratio selects below 1 are treated as a ratio of 2.
package adc_ctrl_pkg;

    // Number of low prescaler bits that must all be one for a tick.
    function automatic int unsigned psc_bits(input int unsigned sel);
        return (sel < 1) ? 1 : sel;
    endfunction

endpackage

// File: rtl/adc_psc.sv
// Module: free-running conversion-clock divider.
// Emits a one-cycle tick every 2^k cycles, k from the select value.
// Assumes a clear restarts the count so the first tick follows a full period.
module adc_psc #(
    parameter int PSC_SEL_W = 3,
    parameter int PSC_W     = (1 << PSC_SEL_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [PSC_SEL_W-1:0] sel,
    output logic                 tick
);
    import adc_ctrl_pkg::*;

    logic [PSC_W-1:0] cnt;
    logic [PSC_W-1:0] mask;

    // Build the mask of low bits that must be all ones for a tick.
    always_comb begin
        for (int i = 0; i < PSC_W; i++) begin
            mask[i] = (i < int'(psc_bits(int'(sel))));
        end
    end

    assign tick = ((cnt & mask) == mask);

    // Divider count, restarted on every conversion start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_trig_edge.sv
// Module: trigger source selector and rising-edge detector.
// Source 0 is the completion flag, sources 1..N-1 are external lines.
// The whole source vector is registered, so moving the selector
// compares like with like and never invents an edge.
module adc_trig_edge #(
    parameter int N_SRC = 8,
    parameter int SEL_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-2:0] ext,
    input  logic             flag,
    input  logic [SEL_W-1:0] sel,
    output logic             edge_det
);
    logic [N_SRC-1:0] src;
    logic [N_SRC-1:0] prev;

    assign src      = {ext, flag};
    assign edge_det = src[sel] & ~prev[sel];

    // Remember every source's last value for per-line edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
        end else begin
            prev <= src;
        end
    end
endmodule

// File: rtl/adc_conv_seq.sv
// Module: conversion sequencer standing in for the converter.
// Counts TICKS prescaler ticks after a start, then pulses done.
// Assumes start is only asserted while idle; rerun keeps it busy.
module adc_conv_seq #(
    parameter int TICKS = 13,
    parameter int CNT_W = $clog2(TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rerun,
    input  logic tick,
    output logic busy,
    output logic done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] cnt;

    assign done = busy & tick & (cnt == LAST);

    // Busy state and tick count across one conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done) begin
            busy <= rerun;
            cnt  <= '0;
        end else if (busy && tick) begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_start_ctrl.sv
// Module: top of the conversion start and auto-trigger controller.
// Gates software and trigger starts, runs the sequencer, keeps the
// completion flag, latches the channel and writes a stub result.
// Assumes flag_clr and start_wr are single-cycle strobes.
module adc_start_ctrl #(
    parameter int N_SRC      = 8,
    parameter int SEL_W      = $clog2(N_SRC),
    parameter int PSC_SEL_W  = 3,
    parameter int CH_W       = 4,
    parameter int SEQ_W      = 6,
    parameter int CONV_TICKS = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_wr,
    input  logic                  pwr_off,
    input  logic                  auto_en,
    input  logic [SEL_W-1:0]      trig_sel,
    input  logic [N_SRC-2:0]      trig_in,
    input  logic [PSC_SEL_W-1:0]  psc_sel,
    input  logic [CH_W-1:0]       chan_sel,
    input  logic                  flag_clr,
    output logic                  busy,
    output logic                  cmp_flag,
    output logic [CH_W-1:0]       cur_chan,
    output logic [CH_W+SEQ_W-1:0] result
);
    logic edge_det;
    logic tick;
    logic done_w;
    logic go;
    logic rerun;
    logic relaunch;
    logic [SEQ_W-1:0] seq;

    // Any start is blocked while powered down or already converting.
    assign go       = ~busy & ~pwr_off & (start_wr | (auto_en & edge_det));
    // Selecting the own flag with auto-trigger on means free-running.
    assign rerun    = auto_en & ~pwr_off & (trig_sel == '0);
    assign relaunch = go | (done_w & rerun);

    adc_trig_edge #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext      (trig_in),
        .flag     (cmp_flag),
        .sel      (trig_sel),
        .edge_det (edge_det)
    );

    adc_psc #(.PSC_SEL_W(PSC_SEL_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (relaunch),
        .sel   (psc_sel),
        .tick  (tick)
    );

    adc_conv_seq #(.TICKS(CONV_TICKS)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go),
        .rerun (rerun),
        .tick  (tick),
        .busy  (busy),
        .done  (done_w)
    );

    // Completion flag: completion wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_flag <= 1'b0;
        end else if (done_w) begin
            cmp_flag <= 1'b1;
        end else if (flag_clr) begin
            cmp_flag <= 1'b0;
        end
    end

    // Channel latch, loaded only when a conversion (re)starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_chan <= '0;
        end else if (relaunch) begin
            cur_chan <= chan_sel;
        end
    end

    // Stub result and completion counter, written at each completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            seq    <= '0;
        end else if (done_w) begin
            result <= {cur_chan, seq};
            seq    <= seq + 1'b1;
        end
    end
endmodule

// File: rtl/adc_start_ctrl_chk.sv
// Module: property checker for adc_start_ctrl, attached by bind.
// Observes ports plus the sequencer's done pulse and the rerun decision.
module adc_start_ctrl_chk #(
    parameter int CH_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pwr_off,
    input logic            flag_clr,
    input logic            busy,
    input logic            cmp_flag,
    input logic [CH_W-1:0] cur_chan,
    input logic            done_w,
    input logic            rerun
);
    p_power_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!pwr_off));

    p_busy_ends_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done_w));

    p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(done_w)) |-> $stable(cur_chan));

    p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_w && !rerun) |=> !busy);

    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_w |=> cmp_flag);

    p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && flag_clr && !done_w) |=> !cmp_flag);

    p_free_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_w && rerun) |=> busy);
endmodule

bind adc_start_ctrl adc_start_ctrl_chk #(.CH_W(CH_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_off  (pwr_off),
    .flag_clr (flag_clr),
    .busy     (busy),
    .cmp_flag (cmp_flag),
    .cur_chan (cur_chan),
    .done_w   (done_w),
    .rerun    (rerun)
);

// File: tb/sim_adc_start_ctrl.sv
// Bench: seeded random conversions plus directed corner cases.
module sim_adc_start_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_wr = 1'b0;
    logic       pwr_off = 1'b0;
    logic       auto_en = 1'b0;
    logic [2:0] trig_sel = 3'd1;
    logic [6:0] trig_in = '0;
    logic [2:0] psc_sel = '0;
    logic [3:0] chan_sel = '0;
    logic       flag_clr = 1'b0;
    logic       busy;
    logic       cmp_flag;
    logic [3:0] cur_chan;
    logic [9:0] result;

    int errors = 0;
    int checks = 0;
    int seq_exp = 0;
    bit done_run = 1'b0;

    always #4 clk = ~clk;

    adc_start_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .pwr_off(pwr_off),
        .auto_en(auto_en), .trig_sel(trig_sel), .trig_in(trig_in),
        .psc_sel(psc_sel), .chan_sel(chan_sel), .flag_clr(flag_clr),
        .busy(busy), .cmp_flag(cmp_flag), .cur_chan(cur_chan), .result(result)
    );

    function automatic int ratio(input int ps);
        return (ps < 1) ? 2 : (1 << ps);
    endfunction

    function automatic int res_exp(input int ch, input int sq);
        return (ch << 6) | (sq % 64);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R6 clear", int'(cmp_flag), 0);
    endtask

    // One conversion, by software strobe or by a trigger edge.
    task automatic conv(input bit use_trig, input int ps, input int ch,
                        input bit noise, input bit clr_end);
        int r = ratio(ps);
        int n = 0;
        int tsel = 1 + $urandom_range(5, 0);
        psc_sel  = 3'(ps);
        chan_sel = 4'(ch);
        trig_sel = 3'(tsel);
        if (use_trig) begin
            auto_en = 1'b1;
            trig_in[tsel-1] = 1'b1;
        end else begin
            auto_en  = 1'($urandom_range(1, 0));   // R8: start works either way
            start_wr = 1'b1;
        end
        @(negedge clk);
        start_wr = 1'b0;
        while (busy && n < 13 * 128 + 8) begin
            n++;
            if (clr_end && n == 13 * r) flag_clr = 1'b1;
            if (noise && n == 3) chan_sel = 4'(ch ^ 4'hA);
            if (use_trig && noise && n == 2) trig_in[tsel-1] = 1'b0;
            if (use_trig && noise && n == 4) trig_in[tsel-1] = 1'b1;
            @(negedge clk);
            flag_clr = 1'b0;
        end
        chk(use_trig ? "R2/R4/R5 duration" : "R2/R8 duration", n, 13 * r);
        chk(clr_end ? "R6 clear vs completion" : "R6 flag set", int'(cmp_flag), 1);
        chk("R3/R10 result", int'(result), res_exp(ch, seq_exp));
        chk("R3 cur_chan", int'(cur_chan), ch);
        seq_exp++;
        if (use_trig) begin
            repeat (3) @(negedge clk);
            chk("R5 held trigger no restart", int'(busy), 0);
            trig_in = '0;
        end
        auto_en = 1'b0;
        @(negedge clk);
        clear_flag();
    endtask

    initial begin
        int bad;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R11 busy", int'(busy), 0);
        chk("R11 flag", int'(cmp_flag), 0);
        chk("R11 chan", int'(cur_chan), 0);
        chk("R11 result", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: R1 power-down blocks both start kinds.
        pwr_off = 1'b1;
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        auto_en = 1'b1; trig_sel = 3'd3; trig_in[2] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 power-down start", int'(busy), 0);
        trig_in = '0; auto_en = 1'b0; pwr_off = 1'b0;
        @(negedge clk);
        conv(1'b0, 1, 7, 1'b0, 1'b0);   // R1 accepted start

        // Directed: R4 edge with auto-trigger off.
        trig_sel = 3'd4; trig_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 auto off ignores edge", int'(busy), 0);
        trig_in = '0;

        // Directed: R9 selecting a line that is already high.
        auto_en = 1'b1; trig_sel = 3'd2; trig_in[4] = 1'b1;
        repeat (2) @(negedge clk);
        trig_sel = 3'd5;
        repeat (4) @(negedge clk);
        chk("R9 select change no edge", int'(busy), 0);
        trig_in = '0; auto_en = 1'b0;
        @(negedge clk);

        // Random conversions.
        for (int it = 0; it < 20; it++) begin
            conv(1'($urandom_range(1, 0)), $urandom_range(5, 0),
                 $urandom_range(15, 0), 1'($urandom_range(1, 0)),
                 1'($urandom_range(1, 0)));
        end
        conv(1'b1, 7, 12, 1'b1, 1'b1);   // largest ratio

        // Directed: R7 free-running.
        psc_sel = 3'd1; chan_sel = 4'd5; auto_en = 1'b1; trig_sel = 3'd0;
        repeat (6) @(negedge clk);
        chk("R7 needs software start", int'(busy), 0);
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        for (int c = 0; c < 3; c++) begin
            bad = 0;
            for (int i = 0; i < 26; i++) begin
                if (!busy) bad++;
                if (c == 0 && i == 5) chan_sel = 4'd9;
                if (c == 2 && i == 0) auto_en = 1'b0;
                @(negedge clk);
            end
            chk("R7 busy through run", bad, 0);
            chk("R7 flag", int'(cmp_flag), 1);
            chk("R7/R3 result", int'(result), res_exp(c == 0 ? 5 : 9, seq_exp));
            chk("R7 continue", int'(busy), (c < 2) ? 1 : 0);
            seq_exp++;
        end
        clear_flag();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done_run = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule